// File: doc/BRIEF.md
# Command Packet Stream Parser

The parser sits behind a command-word fetcher and turns a stream of 32-bit command words into register-write transactions. Each packet opens with a header whose top two bits pick one of four packet kinds: a burst of register writes from a base index (incrementing or fixed), a pair of writes to two independent registers, a payload-free filler word, or an opcode packet. Two opcode values carry a register index as their first body word and are turned into writes relative to a fixed base. Every other opcode is passed, word by word and tagged, to a side port for some other unit to execute.

Payload words are not stored. The input word drives the write or side port directly, and the input ready follows the ready of whichever sink the current word goes to. Header and index words are taken in one cycle each and produce no output. An all-zero header ends the stream for good. An external end-of-stream signal that arrives while a packet still expects words sets a sticky error flag.

Top module: `cmd_stream_parser`

## Requirements
- R1: Header bits [31:30] give the packet kind and bits [25:16] a count N. A kind-0 or kind-3 packet is followed by exactly N+1 words, and the next word after them is read as a header.
- R2: Kind 0 with bit 15 clear writes payload word i to byte address 4*bits[12:0] + 4*i.
- R3: Kind 0 with bit 15 set writes every payload word to byte address 4*bits[12:0].
- R4: Kind 1 ignores the count field and takes exactly two words. The first is written to 4*bits[10:0] and the second to 4*bits[21:11].
- R5: Kind 2 carries no payload and produces no write. The word after it is a header.
- R6: Kind 3 with opcode bits[15:8] = 0x68 consumes its first body word as an index K without any output, then writes the remaining N words to 0x8000 + 4*K + 4*i. When N = 0 no write is made.
- R7: Kind 3 with opcode 0x69 behaves as in R6, with base 0x28000.
- R8: A header of 0x00000000 raises `done` for good. From then on `in_ready` stays low and no write or side transfer is produced.
- R9: For any other kind-3 opcode, each of the N+1 body words appears on the side port with the opcode, and `op_last` is high only on the final word. No write is produced.
- R10: While a payload word is offered and its sink's ready is low, `in_ready` is low and the same transaction stays on the port. Each word is delivered exactly once.
- R11: `parse_err` is set on the cycle after `in_eos` is sampled high while the current packet still expects words. It stays set until reset. `in_eos` between packets has no effect.
- R12: After reset, `done` and `parse_err` are low, `in_ready` is high (a header is expected), and neither output port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle |
| in_data | input | 32 | Command word |
| in_eos | input | 1 | External end-of-stream indication |
| wr_valid | output | 1 | Register write present |
| wr_ready | input | 1 | Write sink accepts |
| wr_addr | output | ADDR_W (20) | Byte address of the write |
| wr_data | output | 32 | Write data |
| op_valid | output | 1 | Opaque body word present |
| op_ready | input | 1 | Side sink accepts |
| op_code | output | 8 | Opcode of the packet in progress |
| op_data | output | 32 | Opaque body word |
| op_last | output | 1 | Final body word of the packet |
| done | output | 1 | Stream terminated |
| parse_err | output | 1 | Sticky truncated-packet error |

## Verification
The checker watches handshake rules on every cycle. A stalled write or side word must hold `in_ready` low, the two output ports are never valid together, and both `done` and `parse_err` keep their value once set. Address arithmetic, the word count of each packet kind, the index-word handling of the two base opcodes, and the point at which the error is raised show up only in the bench's stream table and directed cases. In those cases each emitted address and data word is compared against values worked out from the header fields.

// File: rtl/cps_pkg.sv
// Shared types for the command packet stream parser.
// Assumes the fixed 32-bit header layout described in the brief.
package cps_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 10;
    localparam int REG_W  = 13;
    localparam int PAIR_W = 11;

    typedef enum logic [1:0] {
        PK_REGS = 2'd0,
        PK_PAIR = 2'd1,
        PK_FILL = 2'd2,
        PK_OPQ  = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_BURST,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_BASE,
        ST_FWD,
        ST_DONE
    } pstate_e;

    typedef struct packed {
        pkt_kind_e          kind;
        logic [CNT_W-1:0]   cnt;
        logic [REG_W-1:0]   reg_idx;
        logic               fixed;
        logic [PAIR_W-1:0]  pair_a;
        logic [PAIR_W-1:0]  pair_b;
        logic [7:0]         opcode;
        logic               terminator;
    } hdr_fields_t;

endpackage

// File: rtl/cps_hdr_decode.sv
// Header field extraction. Purely combinational: it slices a command
// word into the fields of every packet kind. Which fields count is
// decided by the caller from the kind.
module cps_hdr_decode
    import cps_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_fields_t       fields
);

    // Slice every field at its fixed header position.
    always_comb begin
        fields.kind       = pkt_kind_e'(word[31:30]);
        fields.cnt        = word[25:16];
        fields.reg_idx    = word[12:0];
        fields.fixed      = word[15];
        fields.pair_a     = word[10:0];
        fields.pair_b     = word[21:11];
        fields.opcode     = word[15:8];
        fields.terminator = (word == '0);
    end

endmodule

// File: rtl/cps_addr_gen.sv
// Write address register. It loads a byte address together with a
// fixed/stride flag, and on each step advances by STRIDE unless fixed.
// Assumes load and step are never high in the same cycle.
module cps_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_fixed,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic              fixed_q;

    // Hold the current address and advance it per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            fixed_q <= 1'b0;
        end else if (load) begin
            addr_q  <= load_addr;
            fixed_q <= load_fixed;
        end else if (step && !fixed_q) begin
            addr_q  <= addr_q + ADDR_W'(STRIDE);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/cps_beat_ctr.sv
// Remaining-word counter. It loads N and counts down once per word;
// last is high when the word on offer is the final one of the packet.
module cps_beat_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Track the words still owed after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/cmd_stream_parser.sv
// Command packet stream parser top. It decodes headers, steers payload
// words straight through to the write port or the opaque side port,
// and follows packet boundaries. There is no payload storage: the input
// word is the output word, and input ready follows the active sink.
// Assumes the upstream source holds in_data stable while in_valid is
// high and in_ready is low.
module cmd_stream_parser #(
    parameter int          ADDR_W   = 20,
    parameter logic [7:0]  CFG_OP   = 8'h68,
    parameter logic [7:0]  CTX_OP   = 8'h69,
    parameter int          CFG_BASE = 32'h0000_8000,
    parameter int          CTX_BASE = 32'h0002_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              in_eos,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [7:0]        op_code,
    output logic [31:0]       op_data,
    output logic              op_last,
    output logic              done,
    output logic              parse_err
);
    import cps_pkg::*;

    localparam int BYTE_SHIFT = 2;

    pstate_e           state_q, state_d;
    hdr_fields_t       hf;
    logic              hs_in;
    logic              ag_load, ag_fixed, ag_step;
    logic [ADDR_W-1:0] ag_addr_in, ag_addr;
    logic              bc_load, bc_dec, bc_last;
    logic [CNT_W-1:0]  bc_val;
    logic              pairb_load, op_load;
    logic [ADDR_W-1:0] pairb_q;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] base_addr;
    logic              mid_packet;

    // Dword index to byte address, truncated to the address width.
    function automatic logic [ADDR_W-1:0] dw2byte(input logic [31:0] idx);
        return ADDR_W'({idx[31-BYTE_SHIFT:0], {BYTE_SHIFT{1'b0}}});
    endfunction

    cps_hdr_decode u_dec (
        .word   (in_data),
        .fields (hf)
    );

    cps_addr_gen #(.ADDR_W(ADDR_W), .STRIDE(4)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ag_load),
        .load_addr  (ag_addr_in),
        .load_fixed (ag_fixed),
        .step       (ag_step),
        .addr       (ag_addr)
    );

    cps_beat_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bc_load),
        .load_val (bc_val),
        .dec      (bc_dec),
        .last     (bc_last)
    );

    // Ready follows the sink of the word expected in the current state.
    always_comb begin
        unique case (state_q)
            ST_HDR, ST_BASE:               in_ready = 1'b1;
            ST_BURST, ST_PAIR_A, ST_PAIR_B: in_ready = wr_ready;
            ST_FWD:                        in_ready = op_ready;
            default:                       in_ready = 1'b0;
        endcase
    end

    assign hs_in = in_valid && in_ready;

    // Base address of the index-carrying opcodes.
    assign base_addr = (op_q == CTX_OP) ? ADDR_W'(CTX_BASE) : ADDR_W'(CFG_BASE);

    // Next state and load/step controls for the address and count units.
    always_comb begin
        state_d    = state_q;
        ag_load    = 1'b0;
        ag_addr_in = '0;
        ag_fixed   = 1'b0;
        bc_load    = 1'b0;
        bc_val     = '0;
        bc_dec     = 1'b0;
        pairb_load = 1'b0;
        op_load    = 1'b0;
        unique case (state_q)
            ST_HDR: if (hs_in) begin
                if (hf.terminator) begin
                    state_d = ST_DONE;
                end else begin
                    unique case (hf.kind)
                        PK_REGS: begin
                            ag_load    = 1'b1;
                            ag_addr_in = dw2byte(32'(hf.reg_idx));
                            ag_fixed   = hf.fixed;
                            bc_load    = 1'b1;
                            bc_val     = hf.cnt;
                            state_d    = ST_BURST;
                        end
                        PK_PAIR: begin
                            ag_load    = 1'b1;
                            ag_addr_in = dw2byte(32'(hf.pair_a));
                            ag_fixed   = 1'b1;
                            pairb_load = 1'b1;
                            state_d    = ST_PAIR_A;
                        end
                        PK_FILL: state_d = ST_HDR;
                        default: begin
                            bc_load = 1'b1;
                            bc_val  = hf.cnt;
                            op_load = 1'b1;
                            state_d = (hf.opcode == CFG_OP || hf.opcode == CTX_OP)
                                      ? ST_BASE : ST_FWD;
                        end
                    endcase
                end
            end
            ST_BURST: if (hs_in) begin
                if (bc_last) state_d = ST_HDR;
                else         bc_dec  = 1'b1;
            end
            ST_PAIR_A: if (hs_in) state_d = ST_PAIR_B;
            ST_PAIR_B: if (hs_in) state_d = ST_HDR;
            ST_BASE: if (hs_in) begin
                ag_load    = 1'b1;
                ag_addr_in = base_addr + dw2byte(in_data);
                ag_fixed   = 1'b0;
                if (bc_last) begin
                    state_d = ST_HDR;
                end else begin
                    bc_dec  = 1'b1;
                    state_d = ST_BURST;
                end
            end
            ST_FWD: if (hs_in) begin
                if (bc_last) state_d = ST_HDR;
                else         bc_dec  = 1'b1;
            end
            default: state_d = state_q;
        endcase
    end

    assign ag_step = hs_in && (state_q == ST_BURST);

    // Parser state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HDR;
        else        state_q <= state_d;
    end

    // Second address of a register pair and the opcode of the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pairb_q <= '0;
            op_q    <= '0;
        end else begin
            if (pairb_load) pairb_q <= dw2byte(32'(hf.pair_b));
            if (op_load)    op_q    <= hf.opcode;
        end
    end

    // Sticky error: end of stream while a packet still owes words.
    assign mid_packet = (state_q != ST_HDR) && (state_q != ST_DONE);

    always_ff @(posedge clk) begin
        if (!rst_n)                   parse_err <= 1'b0;
        else if (in_eos && mid_packet) parse_err <= 1'b1;
    end

    // Pass-through output ports.
    assign wr_valid = in_valid && (state_q == ST_BURST || state_q == ST_PAIR_A ||
                                   state_q == ST_PAIR_B);
    assign wr_addr  = (state_q == ST_PAIR_B) ? pairb_q : ag_addr;
    assign wr_data  = in_data;
    assign op_valid = in_valid && (state_q == ST_FWD);
    assign op_code  = op_q;
    assign op_data  = in_data;
    assign op_last  = bc_last;
    assign done     = (state_q == ST_DONE);

endmodule

// File: rtl/cps_parser_checker.sv
// Cycle-level handshake and sticky-flag properties for the parser,
// attached to every instance of the top through bind.
module cps_parser_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic wr_valid,
    input logic wr_ready,
    input logic op_valid,
    input logic op_ready,
    input logic done,
    input logic parse_err
);

    // R8: a terminated stream accepts nothing
    p_done_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R8: termination is permanent
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R11: the error flag is sticky
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        parse_err |=> parse_err);

    // R10: a stalled write blocks the input
    p_wr_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);

    // R10: a stalled side word blocks the input
    p_op_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |-> !in_ready);

    // R9: a word goes to one sink only
    p_one_sink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && op_valid));

endmodule

bind cmd_stream_parser cps_parser_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .done      (done),
    .parse_err (parse_err)
);

// File: tb/cmd_stream_parser_bench.sv
module cmd_stream_parser_bench;

    localparam int ADDR_W = 20;
    localparam int NVEC   = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_data = '0;
    logic              in_eos = 1'b0;
    logic              wr_valid;
    logic              wr_ready = 1'b1;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              op_valid;
    logic              op_ready = 1'b1;
    logic [7:0]        op_code;
    logic [31:0]       op_data;
    logic              op_last;
    logic              done;
    logic              parse_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cmd_stream_parser #(.ADDR_W(ADDR_W)) u_cmd_stream_parser (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data), .in_eos (in_eos),
        .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_addr (wr_addr), .wr_data (wr_data),
        .op_valid (op_valid), .op_ready (op_ready), .op_code (op_code), .op_data (op_data),
        .op_last (op_last), .done (done), .parse_err (parse_err)
    );

    // Vector: {word[32], kind[2] (0 none, 1 write, 2 side), addr[20], opcode[8], last[1], req[4]}
    localparam logic [66:0] VEC [NVEC] = '{
        {32'h0002_0100, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd1},  // R1 burst header, N=2, idx 0x100
        {32'hA000_0001, 2'd1, 20'h00400, 8'h00, 1'b0, 4'd2},  // R2
        {32'hA000_0002, 2'd1, 20'h00404, 8'h00, 1'b0, 4'd2},  // R2
        {32'hA000_0003, 2'd1, 20'h00408, 8'h00, 1'b0, 4'd1},  // R1 third of N+1
        {32'h0001_9FFF, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd3},  // R3 fixed, idx 0x1FFF
        {32'hB000_0001, 2'd1, 20'h07FFC, 8'h00, 1'b0, 4'd3},  // R3
        {32'hB000_0002, 2'd1, 20'h07FFC, 8'h00, 1'b0, 4'd3},  // R3
        {32'h403F_F805, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd4},  // R4 pair a=5 b=0x7FF, count field 0x3F
        {32'hC100_0001, 2'd1, 20'h00014, 8'h00, 1'b0, 4'd4},  // R4
        {32'hC100_0002, 2'd1, 20'h01FFC, 8'h00, 1'b0, 4'd4},  // R4
        {32'h8000_0000, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd5},  // R5 filler
        {32'hC002_6800, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd6},  // R6 opcode 0x68, N=2
        {32'h0000_0010, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd6},  // R6 index word
        {32'hD000_0001, 2'd1, 20'h08040, 8'h00, 1'b0, 4'd6},  // R6
        {32'hD000_0002, 2'd1, 20'h08044, 8'h00, 1'b0, 4'd6},  // R6
        {32'hC001_6900, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd7},  // R7 opcode 0x69, N=1
        {32'h0000_0003, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd7},  // R7 index word
        {32'hD100_0001, 2'd1, 20'h2800C, 8'h00, 1'b0, 4'd7},  // R7
        {32'hC000_6900, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd6},  // R6 N=0: index only
        {32'h0000_0055, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd6},  // R6 no write
        {32'hC002_2D00, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd9},  // R9 opaque 0x2D, N=2
        {32'hE000_0001, 2'd2, 20'h00000, 8'h2D, 1'b0, 4'd9},  // R9
        {32'hE000_0002, 2'd2, 20'h00000, 8'h2D, 1'b0, 4'd9},  // R9
        {32'hE000_0003, 2'd2, 20'h00000, 8'h2D, 1'b1, 4'd9},  // R9 last
        {32'h0000_0002, 2'd0, 20'h00000, 8'h00, 1'b0, 4'd1},  // R1 single word, idx 2
        {32'hF000_0001, 2'd1, 20'h00008, 8'h00, 1'b0, 4'd1}   // R1
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Drive a word just after the falling edge.
    task automatic offer(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        #2;
    endtask

    task automatic advance();
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R12 reset state
        chk(!done && !parse_err && in_ready && !wr_valid && !op_valid, "R12",
            {59'd0, done, parse_err, in_ready, wr_valid, op_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven stream with both sinks always ready.
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0]       w;
            logic [1:0]        k;
            logic [ADDR_W-1:0] a;
            logic [7:0]        oc;
            logic              lst;
            string             tag;
            w = VEC[i][66:35]; k = VEC[i][34:33]; a = VEC[i][32:13];
            oc = VEC[i][12:5]; lst = VEC[i][4];
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            offer(w);
            if (k == 2'd1)
                chk(wr_valid && !op_valid && in_ready && wr_addr == a && wr_data == w, tag,
                    {wr_valid, op_valid, 10'd0, wr_addr, wr_data}, {2'b10, 10'd0, a, w});
            else if (k == 2'd2)
                chk(op_valid && !wr_valid && in_ready && op_code == oc && op_data == w && op_last == lst,
                    tag, {op_valid, wr_valid, 13'd0, op_last, 8'd0, op_code, op_data},
                    {2'b10, 13'd0, lst, 8'd0, oc, w});
            else
                chk(!wr_valid && !op_valid && in_ready, tag,
                    {61'd0, wr_valid, op_valid, in_ready}, 64'd1);
            advance();
        end

        // R10 write backpressure: header N=1 idx 4
        offer(32'h0001_0004); advance();
        wr_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            offer(32'h0000_1111);
            chk(wr_valid && !in_ready && wr_addr == 20'h10 && wr_data == 32'h1111, "R10 stall",
                {wr_valid, in_ready, 10'd0, wr_addr, wr_data}, {2'b10, 10'd0, 20'h10, 32'h1111});
            @(posedge clk); @(negedge clk);
        end
        wr_ready = 1'b1;
        offer(32'h0000_1111);
        chk(in_ready && wr_addr == 20'h10, "R10 release", {44'd0, wr_addr}, {44'd0, 20'h10});
        advance();
        offer(32'h0000_2222);
        chk(wr_valid && wr_addr == 20'h14 && wr_data == 32'h2222, "R10 next word",
            {12'd0, wr_addr, wr_data}, {12'd0, 20'h14, 32'h2222});
        advance();

        // R10 side-port backpressure: opaque 0x2D, N=0
        offer(32'hC000_2D00); advance();
        op_ready = 1'b0;
        offer(32'h0000_3333);
        chk(op_valid && !in_ready && op_last && op_code == 8'h2D, "R10 op stall",
            {op_valid, in_ready, op_last, 53'd0, op_code}, {3'b101, 53'd0, 8'h2D});
        @(posedge clk); @(negedge clk);
        op_ready = 1'b1;
        #2;
        chk(in_ready && op_valid, "R10 op release", {62'd0, in_ready, op_valid}, 64'h3);
        advance();

        // R11 truncated packet: header N=3, one word, then end of stream
        offer(32'h0003_0000); advance();
        offer(32'h0000_4444); advance();
        chk(!parse_err, "R11 before eos", {63'd0, parse_err}, 64'd0);
        in_eos = 1'b1;
        @(posedge clk); @(negedge clk);
        in_eos = 1'b0;
        #2;
        chk(parse_err, "R11 raised", {63'd0, parse_err}, 64'd1);
        @(posedge clk); @(negedge clk); #2;
        chk(parse_err, "R11 sticky", {63'd0, parse_err}, 64'd1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!parse_err && in_ready && !done, "R11 cleared by reset R12",
            {61'd0, parse_err, in_ready, done}, 64'h2);
        @(negedge clk);
        in_eos = 1'b1;
        @(posedge clk); @(negedge clk);
        in_eos = 1'b0;
        #2;
        chk(!parse_err, "R11 eos between packets", {63'd0, parse_err}, 64'd0);

        // R8 termination
        @(negedge clk);
        offer(32'h0000_0000); advance();
        #2;
        chk(done && !in_ready, "R8 done", {62'd0, done, in_ready}, 64'h2);
        for (int c = 0; c < 3; c++) begin
            offer(32'h0002_0100);
            chk(done && !in_ready && !wr_valid && !op_valid, "R8 ignores words",
                {60'd0, done, in_ready, wr_valid, op_valid}, 64'h8);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;

        summary();
        $finish;
    end

endmodule